// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block computes a three-tap finite impulse response filter on three consecutive samples in every clock cycle. The input word carries one block of three samples. Lane 0 holds the oldest sample of the block and lane 2 the newest. In the same cycle the block produces the three filter outputs that belong to those sample positions. The clock therefore runs at one third of the sample rate. The combinational path from a register to a register stays one multiplier plus an adder chain, as in the serial filter.

Each output lane has its own multipliers and its own adder tree. A bank of registers remembers the newest samples of the previous accepted block. Because each block spans three sample periods, one register step on a lane is worth three sample delays. The two newest samples of block k-1 therefore act as the one-sample and two-sample history of block k. The results are registered, and a valid flag travels with them. The block is meant to sit between a serial-to-parallel converter and a parallel-to-serial converter, and neither converter is part of it.

Top module: `pfir_block`

## Requirements
- R1: Every cycle with `valid_i` high consumes one block of three 16-bit samples. Lane i sits at bits [16i+15:16i] of `x_i`, and lane 0 is the oldest sample. Three 34-bit results come out on `y_o`, with lane i at bits [34i+33:34i].
- R2: Output lane 0 equals a·x(3k) + b·x(3k−1) + c·x(3k−2).
- R3: Output lane 1 equals a·x(3k+1) + b·x(3k) + c·x(3k−1).
- R4: Output lane 2 equals a·x(3k+2) + b·x(3k+1) + c·x(3k).
- R5: Reset clears the history of earlier samples. The first block after reset is computed with x(3k−1) = x(3k−2) = 0. While reset is held, `y_o` reads 0 and `valid_o` reads 0.
- R6: Results appear one clock after their input block, and `valid_o` is `valid_i` delayed by one clock.
- R7: A cycle with `valid_i` low is ignored, whatever value `x_i` carries. The history is kept, `y_o` holds its value, and the next accepted block continues as if no gap had occurred.
- R8: All samples, coefficients and results are signed two's complement. Results are exact at full precision, and this includes every input and coefficient at -32768.
- R9: The coefficients arrive on `coef_i`: a at bits [15:0], b at bits [31:16] and c at bits [47:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_i | input | 48 | Tap coefficients a, b, c, signed |
| valid_i | input | 1 | Input block valid |
| x_i | input | 48 | Three signed samples, lane 0 oldest |
| valid_o | output | 1 | Output block valid |
| y_o | output | 102 | Three signed results, lane 0 oldest |

## Verification
The bench uses the default parameters: 16-bit samples, 16-bit coefficients, three taps and a block of three. With these values the result is 34 bits wide, so driving every sample and coefficient to -32768 reaches the largest magnitude the adder tree can produce. A serial reference model runs one sample at a time. An impulse placed on lane 2 shows whether the history crosses correctly into lanes 0 and 1 of the next block. Idle cycles with junk data and a reset in the middle of a stream test whether the history is kept or cleared.

// File: rtl/pfir_pkg.sv
package pfir_pkg;
  // full-precision result width for a sum of taps signed products
  function automatic int acc_width(input int data_w, input int coef_w, input int taps);
    return data_w + coef_w + $clog2(taps);
  endfunction
endpackage

// File: rtl/pfir_hist.sv
module pfir_hist #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [DEPTH*DATA_W-1:0] newest_i,
  output logic [DEPTH*DATA_W-1:0] hist_o
);
  // one register step per lane = one block delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= '0;
    else if (valid_i) hist_o <= newest_i;
  end

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (valid_i) seen_q <= 1'b1;
  end

  assert_hist_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_o));

  assert_hist_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (hist_o == '0));
endmodule

// File: rtl/pfir_lane.sv
module pfir_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 3,
  parameter int ACC_W  = 34
) (
  input  logic [TAPS*DATA_W-1:0]  win_i,   // slot j holds x(n-j)
  input  logic [TAPS*COEF_W-1:0]  coef_i,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    assign prod[j] = $signed(win_i[j*DATA_W +: DATA_W]) * $signed(coef_i[j*COEF_W +: COEF_W]);
  end

  always_comb begin
    sum_o = '0;
    for (int j = 0; j < TAPS; j++) sum_o = sum_o + ACC_W'(prod[j]);
  end
endmodule

// File: rtl/pfir_block.sv
module pfir_block #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 3,
  parameter int BLOCK  = 3,
  localparam int ACC_W = pfir_pkg::acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TAPS*COEF_W-1:0] coef_i,
  input  logic                   valid_i,
  input  logic [BLOCK*DATA_W-1:0] x_i,
  output logic                   valid_o,
  output logic [BLOCK*ACC_W-1:0] y_o
);
  // history depth must not exceed block size
  localparam int HIST = TAPS - 1;
  localparam int EXT  = BLOCK + HIST;

  logic [HIST*DATA_W-1:0] hist;
  logic [DATA_W-1:0]      ext [EXT];
  logic [TAPS*DATA_W-1:0] win [BLOCK];
  logic signed [ACC_W-1:0] sum [BLOCK];

  pfir_hist #(.DATA_W(DATA_W), .DEPTH(HIST)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .newest_i (x_i[BLOCK*DATA_W-1 -: HIST*DATA_W]),
    .hist_o   (hist)
  );

  // ext[0..HIST-1]: previous block tail, ext[HIST+i]: current lane i
  always_comb begin
    for (int m = 0; m < HIST; m++)  ext[m] = hist[m*DATA_W +: DATA_W];
    for (int i = 0; i < BLOCK; i++) ext[HIST+i] = x_i[i*DATA_W +: DATA_W];
    for (int i = 0; i < BLOCK; i++)
      for (int j = 0; j < TAPS; j++)
        win[i][j*DATA_W +: DATA_W] = ext[i+HIST-j];
  end

  for (genvar i = 0; i < BLOCK; i++) begin : g_lane
    pfir_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_lane (
      .win_i  (win[i]),
      .coef_i (coef_i),
      .sum_o  (sum[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i)
        for (int i = 0; i < BLOCK; i++) y_o[i*ACC_W +: ACC_W] <= sum[i];
    end
  end

  assert_valid_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));
endmodule

// File: tb/pfir_block_tb_top.sv
`timescale 1ns/1ps
module pfir_block_tb_top;
  localparam int DW = 16, CW = 16, TAPS = 3, BLK = 3;
  localparam int AW = DW + CW + 2;
  localparam time TCLK = 20ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [TAPS*CW-1:0] coef;
  logic valid_in;
  logic [BLK*DW-1:0] x_in;
  logic valid_out;
  logic [BLK*AW-1:0] y_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint ca, cb, cc, s1, s2;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(TCLK/2) clk = ~clk;

  pfir_block #(.DATA_W(DW), .COEF_W(CW), .TAPS(TAPS), .BLOCK(BLK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .coef_i(coef), .valid_i(valid_in),
    .x_i(x_in), .valid_o(valid_out), .y_o(y_out)
  );

  function automatic longint lane_y(input int i);
    logic signed [AW-1:0] v;
    v = y_out[i*AW +: AW];
    return longint'(v);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_coef(input longint a, input longint b, input longint c);
    ca = a; cb = b; cc = c;
    coef = {CW'(c), CW'(b), CW'(a)}; // R9 layout
  endtask

  // drive one block at a negedge, check its results at the next negedge
  task automatic send(input string req, input longint x0, input longint x1, input longint x2);
    longint xs[3];
    longint ys[3];
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    for (int i = 0; i < 3; i++) begin
      ys[i] = ca*xs[i] + cb*s1 + cc*s2;
      s2 = s1; s1 = xs[i];
    end
    valid_in = 1'b1;
    x_in = {DW'(x2), DW'(x1), DW'(x0)};
    @(posedge clk); @(negedge clk);
    check({req, " R6 valid"}, longint'(valid_out), 1);
    check({req, " R2 lane0"}, lane_y(0), ys[0]);
    check({req, " R3 lane1"}, lane_y(1), ys[1]);
    check({req, " R4 lane2"}, lane_y(2), ys[2]);
  endtask

  task automatic idle(input int n);
    logic [BLK*AW-1:0] held;
    held = y_out;
    for (int k = 0; k < n; k++) begin
      valid_in = 1'b0;
      x_in = {lfsr[15:0], lfsr[31:16], lfsr[23:8]};
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      @(posedge clk); @(negedge clk);
      check("R7 idle valid low", longint'(valid_out), 0);
      check("R7 idle output held", longint'(y_out == held), 1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid_in = 1'b0; s1 = 0; s2 = 0;
    @(negedge clk);
    check("R5 reset y zero", longint'(y_out == '0), 1);
    check("R6 reset valid zero", longint'(valid_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_impulse();
    set_coef(3, -5, 7);
    send("R1 impulse lane0", 1, 0, 0);
    send("R1 impulse tail", 0, 0, 0);
    send("R1 impulse lane2", 0, 0, 1);
    send("R1 impulse cross", 0, 0, 0);
    send("R1 impulse flush", 0, 0, 0);
  endtask

  task automatic t_ramp();
    set_coef(2, 1, -1);
    for (int k = 0; k < 6; k++) send("R1 ramp", 3*k-7, 3*k-6, 3*k-5);
  endtask

  task automatic t_extremes();
    set_coef(-32768, -32768, -32768);
    send("R8 min all", -32768, -32768, -32768);
    send("R8 min all again", -32768, -32768, -32768);
    set_coef(32767, -32768, 32767);
    send("R8 mixed", 32767, -32768, 32767);
    send("R8 mixed swap", -32768, 32767, -32768);
  endtask

  task automatic t_gaps();
    set_coef(11, -13, 17);
    send("R7 before gap", 100, -200, 300);
    idle(3);
    send("R7 after gap", -400, 500, -600);
    idle(1);
    send("R7 after short gap", 7, 8, 9);
  endtask

  task automatic t_mid_reset();
    set_coef(1, 1000, -1000);
    send("R5 prefill", 123, -456, 789);
    do_reset();
    send("R5 first after reset", 5, 6, 7);
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++) begin
      if (k % 10 == 0) set_coef(longint'($signed(lfsr[15:0])), longint'($signed(lfsr[31:16])),
                                longint'($signed(lfsr[23:8])));
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      send("R1 random", longint'($signed(lfsr[15:0])), longint'($signed(lfsr[31:16])),
           longint'($signed(lfsr[27:12])));
      if (k % 7 == 3) idle(1);
    end
  endtask

  initial begin
    rst_n = 1'b0; valid_in = 1'b0; x_in = '0; coef = '0;
    ca = 0; cb = 0; cc = 0; s1 = 0; s2 = 0;
    repeat (2) @(negedge clk);
    do_reset();
    t_impulse();
    t_ramp();
    t_extremes();
    t_gaps();
    t_mid_reset();
    t_random();
    valid_in = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule